// File: doc/BRIEF.md
# Over-Current Fault Latch Controller

This block is the digital protection core for a high-side gate driver. Every clock it receives a digitized current-sense sample, a logic-level on/off command, a nominal trip level and two status flags: one for a drain-source voltage error on the external switch and one for supply undervoltage. It drives a gate-enable output and a diagnostic flag.

When the sense sample stays above the active trip level for a programmable number of consecutive cycles, the gate is forced off at once and the controller locks into a fault state with the diagnostic flag raised. Brief excursions, such as those caused by supply disturbances, are filtered out. The only way out of the fault is a high-to-low transition of the command. A standby window of programmable length follows, during which the command cannot turn the gate on. When the window ends, the flag drops and the gate follows the command again. The active trip level is reduced while either status flag is set.

Top module: `ocpGuard`

## Requirements
- R1: While `rstN` is low, `gateEn` and `diagFlag` are both 0, whatever the inputs. After reset the controller is in normal operation with no fault and cleared counters.
- R2: In normal operation with no trip pending, `gateEn` equals `cmdIn` and `diagFlag` is 0.
- R3: A trip occurs at the clock edge that samples the DELAY_CYC-th consecutive cycle with `senseVal` above the active level. During that cycle `gateEn` is already 0. From the next cycle on, `diagFlag` is 1.
- R4: A run of fewer than DELAY_CYC consecutive over-level samples causes no trip. Any sample at or below the level restarts the count from zero.
- R5: The comparison is strict: `senseVal` equal to the active level is not over-level.
- R6: In the fault state `gateEn` is 0 and `diagFlag` is 1, regardless of `cmdIn` and `senseVal`. The fault state is left only at an edge where `cmdIn` is sampled 0 after having been sampled 1 at the previous edge.
- R7: The release edge starts a standby window of STANDBY_CYC cycles. During the window `gateEn` is 0 and `diagFlag` stays 1 while `cmdIn` is ignored. After the window `diagFlag` is 0 and `gateEn` follows `cmdIn`.
- R8: While `vdsErr` is 1 and `uvFlag` is 0, the active level is floor(`thrNominal` * 169 / 256), which is about 66 %.
- R9: While `uvFlag` is 1, the active level is floor(`thrNominal` / 2), whatever the value of `vdsErr`.
- R10: No trip can occur during the standby window, even with `senseVal` over-level for longer than DELAY_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| senseVal | input | SENSE_W | Digitized current-sense sample |
| thrNominal | input | SENSE_W | Nominal trip level |
| cmdIn | input | 1 | Gate on/off command |
| vdsErr | input | 1 | Drain-source voltage error flag, reduces level to about 66 % |
| uvFlag | input | 1 | Supply undervoltage flag, reduces level to 50 % |
| gateEn | output | 1 | Gate enable to the driver stage |
| diagFlag | output | 1 | Diagnostic fault indication |

## Verification
A filter counter that is off by one moves the rapid-off drop of `gateEn` one cycle early or late relative to the over-level run, so the per-clock model sees the error within the same trip. A lost release edge or a wrong standby length keeps `diagFlag` high too long, or lets it fall too soon, and this shows at the exact cycle the window should end. A wrong scaled level shows as a trip or a non-trip at the single sample value that sits on the boundary.

// File: rtl/ocpPkg.sv
package ocpPkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LATCH = 2'd1,
    ST_HOLD  = 2'd2
  } ocpState_t;

  typedef struct packed {
    logic filtRun;
    logic holdRun;
  } ocpStrobe_t;

endpackage

// File: rtl/ocpDatapath.sv
module ocpDatapath #(
  parameter int SENSE_W     = 12,
  parameter int DELAY_CYC   = 500,
  parameter int STANDBY_CYC = 2000000,
  parameter int FRAC_SHIFT  = 8,
  parameter int VDS_NUM     = 169,
  parameter int UV_NUM      = 128
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SENSE_W-1:0]      senseVal,
  input  logic [SENSE_W-1:0]      thrNominal,
  input  logic                    vdsErr,
  input  logic                    uvFlag,
  input  ocpPkg::ocpStrobe_t      strobe,
  output logic                    tripHit,
  output logic                    holdDone
);

  localparam int PROD_W  = SENSE_W + FRAC_SHIFT;
  localparam int FILT_W  = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam int STBY_W  = (STANDBY_CYC > 1) ? $clog2(STANDBY_CYC) : 1;
  localparam logic [FILT_W-1:0] FILT_LAST = FILT_W'(DELAY_CYC - 1);
  localparam logic [STBY_W-1:0] STBY_LAST = STBY_W'(STANDBY_CYC - 1);

  // scaled trip levels by multiply and shift
  logic [PROD_W-1:0]  vdsProd;
  logic [PROD_W-1:0]  uvProd;
  logic [SENSE_W-1:0] vdsLevel;
  logic [SENSE_W-1:0] uvLevel;
  logic [SENSE_W-1:0] activeLevel;
  logic               overNow;

  assign vdsProd  = PROD_W'(thrNominal) * PROD_W'(VDS_NUM);
  assign uvProd   = PROD_W'(thrNominal) * PROD_W'(UV_NUM);
  assign vdsLevel = vdsProd[PROD_W-1:FRAC_SHIFT];
  assign uvLevel  = uvProd[PROD_W-1:FRAC_SHIFT];

  always_comb begin
    if (uvFlag)      activeLevel = uvLevel;
    else if (vdsErr) activeLevel = vdsLevel;
    else             activeLevel = thrNominal;
  end

  assign overNow = senseVal > activeLevel;

  // detection filter
  logic [FILT_W-1:0] filtCnt;

  assign tripHit = strobe.filtRun && overNow && (filtCnt == FILT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtCnt <= '0;
    end else if (!strobe.filtRun || !overNow || tripHit) begin
      filtCnt <= '0;
    end else begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  // standby window timer
  logic [STBY_W-1:0] stbyCnt;

  assign holdDone = strobe.holdRun && (stbyCnt == STBY_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbyCnt <= '0;
    end else if (!strobe.holdRun || holdDone) begin
      stbyCnt <= '0;
    end else begin
      stbyCnt <= stbyCnt + 1'b1;
    end
  end

endmodule

// File: rtl/ocpControl.sv
module ocpControl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdIn,
  input  logic               tripHit,
  input  logic               holdDone,
  output ocpPkg::ocpStrobe_t strobe,
  output ocpPkg::ocpState_t  stateQ,
  output logic               gateEn,
  output logic               diagFlag
);
  import ocpPkg::*;

  ocpState_t stateD;
  logic      cmdPrev;
  logic      cmdFall;

  assign cmdFall = cmdPrev && !cmdIn;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_RUN:   if (tripHit)  stateD = ST_LATCH;
      ST_LATCH: if (cmdFall)  stateD = ST_HOLD;
      ST_HOLD:  if (holdDone) stateD = ST_RUN;
      default:                stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_RUN;
      cmdPrev <= 1'b0;
    end else begin
      stateQ  <= stateD;
      cmdPrev <= cmdIn;
    end
  end

  assign strobe.filtRun = (stateQ == ST_RUN);
  assign strobe.holdRun = (stateQ == ST_HOLD);

  // rapid off: gate drops in the cycle the trip is detected
  assign gateEn   = rstN && (stateQ == ST_RUN) && cmdIn && !tripHit;
  assign diagFlag = rstN && (stateQ != ST_RUN);

endmodule

// File: rtl/ocpGuard.sv
module ocpGuard #(
  parameter int SENSE_W     = 12,
  parameter int DELAY_CYC   = 500,
  parameter int STANDBY_CYC = 2000000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SENSE_W-1:0] senseVal,
  input  logic [SENSE_W-1:0] thrNominal,
  input  logic               cmdIn,
  input  logic               vdsErr,
  input  logic               uvFlag,
  output logic               gateEn,
  output logic               diagFlag
);

  ocpPkg::ocpStrobe_t strobe;
  ocpPkg::ocpState_t  stateQ;
  logic               tripHit;
  logic               holdDone;

  ocpDatapath #(
    .SENSE_W    (SENSE_W),
    .DELAY_CYC  (DELAY_CYC),
    .STANDBY_CYC(STANDBY_CYC)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .senseVal  (senseVal),
    .thrNominal(thrNominal),
    .vdsErr    (vdsErr),
    .uvFlag    (uvFlag),
    .strobe    (strobe),
    .tripHit   (tripHit),
    .holdDone  (holdDone)
  );

  ocpControl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdIn   (cmdIn),
    .tripHit (tripHit),
    .holdDone(holdDone),
    .strobe  (strobe),
    .stateQ  (stateQ),
    .gateEn  (gateEn),
    .diagFlag(diagFlag)
  );

endmodule

// File: rtl/ocpGuardChecker.sv
module ocpGuardChecker (
  input logic              clk,
  input logic              rstN,
  input logic              cmdIn,
  input logic              gateEn,
  input logic              diagFlag,
  input logic              tripHit,
  input logic              holdDone,
  input ocpPkg::ocpState_t stateQ
);
  import ocpPkg::*;

  // R1: outputs are quiet while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (!gateEn && !diagFlag));

  // R2: gate never on without the command, never on with a fault shown
  p_gate_needs_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    gateEn |-> (cmdIn && !diagFlag));

  // R3: a trip strobe from the datapath leads to the fault flag
  p_trip_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    tripHit |=> (diagFlag && stateQ == ST_LATCH));

  // R3: the rapid-off path holds the gate low during the trip cycle
  p_trip_gate_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    tripHit |-> !gateEn);

  // R6: latch stays while the command is high
  p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LATCH && cmdIn) |=> (stateQ == ST_LATCH));

  // R6: release only through a falling command
  p_release_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LATCH && $past(cmdIn) && !cmdIn) |=> (stateQ == ST_HOLD));

  // R7: gate held off and flag kept up in the standby window
  p_standby_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD) |-> (!gateEn && diagFlag));

  // R7: window end clears the flag
  p_standby_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    holdDone |=> !diagFlag);

  // R10: no trip strobe outside normal operation
  p_no_trip_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_RUN) |-> !tripHit);

endmodule

bind ocpGuard ocpGuardChecker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .cmdIn   (cmdIn),
  .gateEn  (gateEn),
  .diagFlag(diagFlag),
  .tripHit (tripHit),
  .holdDone(holdDone),
  .stateQ  (stateQ)
);

// File: tb/test_ocpGuard.sv
`timescale 1ns/100ps
module test_ocpGuard;

  localparam int SW = 12;
  localparam int D  = 6;
  localparam int S  = 20;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [SW-1:0] senseVal = '0;
  logic [SW-1:0] thrNominal = 12'd1000;
  logic          cmdIn = 1'b0;
  logic          vdsErr = 1'b0;
  logic          uvFlag = 1'b0;
  logic          gateEn;
  logic          diagFlag;

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  string curTag  = "R1";

  always #2.5 clk = ~clk;

  ocpGuard #(.SENSE_W(SW), .DELAY_CYC(D), .STANDBY_CYC(S)) i_ocpGuard (
    .clk(clk), .rstN(rstN), .senseVal(senseVal), .thrNominal(thrNominal),
    .cmdIn(cmdIn), .vdsErr(vdsErr), .uvFlag(uvFlag),
    .gateEn(gateEn), .diagFlag(diagFlag)
  );

  // behavioural reference: mode 0 normal, 1 fault, 2 standby
  int mMode = 0, mRun = 0, mWait = 0;
  bit mLastCmd = 0;

  function automatic int level(int nom, bit v, bit u);
    if (u) return nom / 2;
    if (v) return (nom * 169) / 256;
    return nom;
  endfunction

  always @(negedge clk) begin
    bit eG, eD, over, fire;
    if (!rstN) begin
      eG = 0; eD = 0;
      mMode = 0; mRun = 0; mWait = 0; mLastCmd = 0;
    end else begin
      over = int'(senseVal) > level(int'(thrNominal), vdsErr, uvFlag);
      fire = 0;
      if (mMode == 0) begin
        fire = over && (mRun + 1 >= D);
        eG = cmdIn && !fire; eD = 0;
        if (fire) begin mMode = 1; mRun = 0; end
        else mRun = over ? mRun + 1 : 0;
      end else if (mMode == 1) begin
        eG = 0; eD = 1;
        if (mLastCmd && !cmdIn) begin mMode = 2; mWait = 0; end
      end else begin
        eG = 0; eD = 1;
        mWait++;
        if (mWait >= S) begin mMode = 0; mWait = 0; end
      end
      mLastCmd = cmdIn;
    end
    nChecks++;
    if (gateEn !== eG || diagFlag !== eD) begin
      nFails++;
      $display("FAIL %s model t=%0t gate=%b/%b diag=%b/%b (actual/expected)",
               curTag, $time, gateEn, eG, diagFlag, eD);
    end
  end

  task automatic setIn(int s, bit c, bit v, bit u);
    senseVal = SW'(s); cmdIn = c; vdsErr = v; uvFlag = u;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, bit g, bit d);
    #0.5;
    nChecks++;
    if (gateEn !== g || diagFlag !== d) begin
      nFails++;
      $display("FAIL %s directed gate=%b exp %b diag=%b exp %b", tag, gateEn, g, diagFlag, d);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    curTag = "R1";
    setIn(2000, 1, 0, 0);
    cyc(3);
    chk("R1", 0, 0);
    setIn(100, 0, 0, 0);
    rstN = 1'b1;
    cyc(1);

    curTag = "R2";
    setIn(100, 1, 0, 0); chk("R2", 1, 0);
    cyc(2); setIn(100, 0, 0, 0); chk("R2", 0, 0);
    cyc(1); setIn(100, 1, 0, 0); cyc(1); chk("R2", 1, 0);

    curTag = "R4";
    setIn(1001, 1, 0, 0); cyc(4);
    setIn(900, 1, 0, 0); cyc(1); chk("R4", 1, 0);
    setIn(1001, 1, 0, 0); cyc(4);
    setIn(900, 1, 0, 0); cyc(1); chk("R4", 1, 0);

    curTag = "R5";
    setIn(1000, 1, 0, 0); cyc(10); chk("R5", 1, 0);

    curTag = "R3";
    setIn(1001, 1, 0, 0); cyc(5); chk("R3", 0, 0);
    cyc(1); chk("R3", 0, 1);

    curTag = "R6";
    setIn(100, 1, 0, 0); cyc(10); chk("R6", 0, 1);
    setIn(3000, 1, 0, 0); cyc(3); chk("R6", 0, 1);
    setIn(100, 0, 0, 0); cyc(1); chk("R6", 0, 1);

    curTag = "R10";
    setIn(1001, 1, 0, 0); cyc(10); chk("R10", 0, 1);
    curTag = "R7";
    setIn(100, 1, 0, 0); cyc(8); chk("R7", 0, 1);
    cyc(1); chk("R7", 0, 1);
    cyc(1); chk("R7", 1, 0);

    curTag = "R8";
    setIn(660, 1, 1, 0); cyc(10); chk("R8", 1, 0);
    setIn(661, 1, 1, 0); cyc(5); chk("R8", 0, 0);
    cyc(1); chk("R8", 0, 1);
    setIn(100, 0, 0, 0); cyc(1);
    cyc(S); chk("R7", 0, 0);
    setIn(100, 1, 0, 0); chk("R7", 1, 0);

    curTag = "R9";
    cyc(1);
    setIn(500, 1, 1, 1); cyc(10); chk("R9", 1, 0);
    setIn(600, 1, 0, 1); cyc(5); chk("R9", 0, 0);
    cyc(1); chk("R9", 0, 1);
    setIn(100, 0, 0, 0); cyc(1);
    cyc(S); chk("R9", 0, 0);
    setIn(501, 1, 1, 1); cyc(6); chk("R9", 0, 1);

    curTag = "R1";
    rstN = 1'b0; cyc(1); chk("R1", 0, 0);
    rstN = 1'b1; setIn(100, 1, 0, 0); cyc(1); chk("R1", 1, 0);
    cyc(2);
    finishRun();
  end

endmodule